// File: doc/BRIEF.md
# Compare-Driven Clock Generator

This block derives a slow, programmable clock from the free-running system clock. A single up-counter advances once per enabled cycle. When the count reaches a high reference it returns to zero, so one output period spans the high reference plus one system cycles. A low reference sets the point in each period where the output goes high. A small two-state machine raises the output one cycle after the low-reference match and lowers it one cycle after the wrap event. The high time is therefore the difference between the two references.

The block also exposes three single-cycle strobes that other logic can use as timing events: a low-reference match, a high-reference match, and a counter-return-to-zero event. The generated clock is a registered signal in the system clock domain. Both references are captured only when the counter wraps or is cleared, so software may rewrite them at any time without producing a short pulse. For example, references of 24 and 49 on a 100 MHz system clock give a 2 MHz output with a 50 % duty cycle.

Top module: `match_clock_gen`

## Requirements
- R1: Reset or a synchronous clear returns the counter to zero and the output to low on the next edge, and loads both references from the inputs; the zero strobe is high in every cycle that clear is high.
- R2: While enabled, the counter advances by one per cycle and returns to zero in the cycle after it equals the captured high reference, giving an output period of high reference + 1 system cycles.
- R3: The low-match strobe is high for exactly the cycles in which the block is enabled and the count equals the captured low reference.
- R4: The high-match strobe is high for exactly the cycles in which the block is enabled and the count equals the captured high reference. The zero strobe is high when the high-match strobe is high or clear is high, and low otherwise.
- R5: The output rises one cycle after a low-match strobe and falls one cycle after a zero strobe. Its high time is high reference − low reference cycles (references 24 and 49 give period 50, high 25).
- R6: While enable is low, the counter holds its value, all strobes other than a clear-driven zero strobe stay low, and the output is low from the next cycle on. Counting resumes from the held value.
- R7: A change to the references between wraps does not affect the current period; the new values first apply after the next wrap.
- R8: When the low reference is greater than or equal to the high reference, the output stays low, because the zero event takes priority over a simultaneous low match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count and output enable |
| clr | input | 1 | Synchronous clear of counter and output state |
| ref_lo | input | CNT_W | Low compare reference (rising point) |
| ref_hi | input | CNT_W | High compare reference (wrap point) |
| clk_out | output | 1 | Generated registered clock |
| zero_stb | output | 1 | Counter-return-to-zero strobe |
| match1_stb | output | 1 | Low-reference match strobe |
| match2_stb | output | 1 | High-reference match strobe |

## Verification
The three strobes are combinational from the counter and the captured references, so they are due in the same cycle as the count that causes them. The bench compares them at the falling edge after the inputs have settled. The output and the counter each sit one register behind their causes, so a low match, a zero event, a clear or a dropped enable shows on the output at the following falling edge. The bench's behavioural model advances at the rising edge and is compared half a cycle later, so the one-cycle delay is reproduced. Period and high-time measurements count the falling edges between observed output transitions, which keeps them independent of this latency.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    typedef enum logic {
        OUT_LOW  = 1'b0,
        OUT_HIGH = 1'b1
    } out_state_e;

    typedef struct packed {
        logic zero;
        logic match1;
        logic match2;
    } evt_t;

    // Falling event beats rising event; a stopped generator parks low.
    function automatic out_state_e next_out(out_state_e cur, logic run, evt_t ev);
        if (!run || ev.zero) begin
            return OUT_LOW;
        end
        if (ev.match1) begin
            return OUT_HIGH;
        end
        return cur;
    endfunction

endpackage

// File: rtl/mcg_refs.sv
module mcg_refs #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] lo_in,
    input  logic [CNT_W-1:0] hi_in,
    output logic [CNT_W-1:0] lo_q,
    output logic [CNT_W-1:0] hi_q
);

    // References are captured only at period boundaries.
    always_ff @(posedge clk) begin
        if (rst || load) begin
            lo_q <= lo_in;
            hi_q <= hi_in;
        end
    end

endmodule

// File: rtl/mcg_counter.sv
module mcg_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_q
);

    always_ff @(posedge clk) begin
        if (rst || clr || restart) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mcg_events.sv
module mcg_events
    import mcg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] lo_ref,
    input  logic [CNT_W-1:0] hi_ref,
    output evt_t             ev
);

    logic run;

    always_comb begin
        run       = en && !rst;
        ev.match1 = run && (cnt == lo_ref);
        ev.match2 = run && (cnt == hi_ref);
        ev.zero   = !rst && (clr || ev.match2);
    end

endmodule

// File: rtl/mcg_out_fsm.sv
module mcg_out_fsm
    import mcg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  evt_t ev,
    output logic clk_out
);

    out_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OUT_LOW;
        end else begin
            state_q <= next_out(state_q, en, ev);
        end
    end

    assign clk_out = (state_q == OUT_HIGH);

endmodule

// File: rtl/match_clock_gen.sv
module match_clock_gen
    import mcg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  logic [CNT_W-1:0] ref_lo,
    input  logic [CNT_W-1:0] ref_hi,
    output logic             clk_out,
    output logic             zero_stb,
    output logic             match1_stb,
    output logic             match2_stb
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lo_q;
    logic [CNT_W-1:0] hi_q;
    evt_t             ev;

    mcg_refs #(.CNT_W(CNT_W)) u_refs (
        .clk   (clk),
        .rst   (rst),
        .load  (ev.zero),
        .lo_in (ref_lo),
        .hi_in (ref_hi),
        .lo_q  (lo_q),
        .hi_q  (hi_q)
    );

    mcg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .en      (en),
        .restart (ev.match2),
        .cnt_q   (cnt)
    );

    mcg_events #(.CNT_W(CNT_W)) u_evt (
        .rst    (rst),
        .en     (en),
        .clr    (clr),
        .cnt    (cnt),
        .lo_ref (lo_q),
        .hi_ref (hi_q),
        .ev     (ev)
    );

    mcg_out_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .ev      (ev),
        .clk_out (clk_out)
    );

    assign zero_stb   = ev.zero;
    assign match1_stb = ev.match1;
    assign match2_stb = ev.match2;

endmodule

// File: rtl/mcg_checker.sv
module mcg_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic clr,
    input logic clk_out,
    input logic zero_stb,
    input logic match1_stb,
    input logic match2_stb
);

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        clr |=> !clk_out); // R1

    AST_RISE_AFTER_M1: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> $past(match1_stb)); // R5

    AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_out) |-> ($past(zero_stb) || !$past(en))); // R5

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> !clk_out); // R6

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!match1_stb && !match2_stb)); // R6

    AST_ZERO_WINS: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> !$past(zero_stb)); // R8

endmodule

bind match_clock_gen mcg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .clr        (clr),
    .clk_out    (clk_out),
    .zero_stb   (zero_stb),
    .match1_stb (match1_stb),
    .match2_stb (match2_stb)
);

// File: tb/match_clock_gen_bench.sv
module match_clock_gen_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         clr = 1'b0;
    logic [W-1:0] ref_lo = 8'd24;
    logic [W-1:0] ref_hi = 8'd49;
    logic         clk_out;
    logic         zero_stb;
    logic         match1_stb;
    logic         match2_stb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_cnt = 0;
    int m_lo = 0;
    int m_hi = 0;
    bit m_out = 1'b0;

    always #10 clk = ~clk;

    match_clock_gen #(.CNT_W(W)) u_match_clock_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .clr        (clr),
        .ref_lo     (ref_lo),
        .ref_hi     (ref_hi),
        .clk_out    (clk_out),
        .zero_stb   (zero_stb),
        .match1_stb (match1_stb),
        .match2_stb (match2_stb)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // model advance on the rising edge, from pre-edge values
    always @(posedge clk) begin
        bit e1;
        bit e2;
        bit ez;
        if (rst) begin
            m_cnt = 0;
            m_lo  = int'(ref_lo);
            m_hi  = int'(ref_hi);
            m_out = 1'b0;
        end else begin
            e1 = en && (m_cnt == m_lo);
            e2 = en && (m_cnt == m_hi);
            ez = clr || e2;
            if (!en || ez) m_out = 1'b0;
            else if (e1)   m_out = 1'b1;
            if (clr || e2) begin
                m_cnt = 0;
                m_lo  = int'(ref_lo);
                m_hi  = int'(ref_hi);
            end else if (en) begin
                m_cnt = (m_cnt + 1) % 256;
            end
        end
    end

    // per-cycle comparison half a cycle after the edge
    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            chk("R5 clk_out vs model", int'(clk_out), int'(m_out));
            chk("R3 match1_stb vs model", int'(match1_stb), int'(en && (m_cnt == m_lo)));
            chk("R4 match2_stb vs model", int'(match2_stb), int'(en && (m_cnt == m_hi)));
            chk("R4 zero_stb vs model", int'(zero_stb), int'(clr || (en && (m_cnt == m_hi))));
        end
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic measure(int lo, int hi);
        int r1;
        int r2;
        int f1;
        bit prev;
        r1 = -1; r2 = -1; f1 = -1;
        ref_lo = W'(lo);
        ref_hi = W'(hi);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        prev = clk_out;
        for (int i = 0; i < 4 * (hi + 1) + 10; i++) begin
            @(negedge clk);
            if (!prev && clk_out) begin
                if (r1 < 0) r1 = i;
                else if (r2 < 0) r2 = i;
            end
            if (prev && !clk_out && r1 >= 0 && f1 < 0) f1 = i;
            prev = clk_out;
        end
        chk("R2 period", r2 - r1, hi + 1);
        chk("R5 high time", f1 - r1, hi - lo);
    endtask

    task automatic stays_low(int lo, int hi);
        int highs;
        highs = 0;
        ref_lo = W'(lo);
        ref_hi = W'(hi);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        for (int i = 0; i < 4 * (hi + 1) + 10; i++) begin
            @(negedge clk);
            if (clk_out) highs++;
        end
        chk("R8 output high cycles", highs, 0);
    endtask

    task automatic pulse_len(output int len);
        len = 0;
        for (int i = 0; i < 200 && !clk_out; i++) @(negedge clk);
        for (int i = 0; i < 200 && clk_out; i++) begin
            len++;
            @(negedge clk);
        end
    endtask

    initial begin
        int len;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state with enable low
        chk("R1 reset clk_out", int'(clk_out), 0);
        chk("R1 reset match1", int'(match1_stb), 0);
        chk("R1 reset zero", int'(zero_stb), 0);

        en = 1'b1;
        measure(24, 49);   // R5 named example: 50 / 25
        measure(0, 3);
        measure(1, 2);
        measure(10, 20);

        stays_low(7, 7);   // R8 equal references
        stays_low(9, 4);   // R8 low above high

        // R7: mid-period reference rewrite
        ref_lo = 8'd10;
        ref_hi = 8'd20;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        repeat (5) @(negedge clk);
        ref_lo = 8'd2;
        ref_hi = 8'd5;
        pulse_len(len);
        chk("R7 old period high time", len, 10);
        pulse_len(len);
        chk("R7 new period high time", len, 3);

        // R6: enable drop while the output is high
        ref_lo = 8'd24;
        ref_hi = 8'd49;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        for (int i = 0; i < 200 && !clk_out; i++) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R6 output low after enable drop", int'(clk_out), 0);
        repeat (10) begin
            @(negedge clk);
            chk("R6 no match strobes while off", int'(match1_stb || match2_stb), 0);
        end
        en = 1'b1;
        repeat (120) @(negedge clk);

        // R1: clear in the middle of a high phase
        for (int i = 0; i < 200 && !clk_out; i++) @(negedge clk);
        clr = 1'b1;
        #1;
        chk("R1 zero strobe during clear", int'(zero_stb), 1);
        @(negedge clk);
        clr = 1'b0;
        chk("R1 output low after clear", int'(clk_out), 0);
        pulse_len(len);
        chk("R1 first pulse after clear", len, 25);

        repeat (5) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule